// File: doc/BRIEF.md
# Multiprocessor Interrupt Level Router

This block gathers 32 shared device request lines together with private software and timer requests for up to 16 processors. For every processor it computes the highest active priority level, from 0 to 15, and presents that level as one raised line out of fifteen. Shared device requests are delivered only to the processor currently chosen as target. Every other processor sees only its own private requests.

Each device source has a fixed level, taken from a parameter table. The default table gives source i the level i modulo 16. A source whose level is 0 never becomes pending. Software uses one write port with separate set and clear strobes to change private soft-request bits, the shared disable word and the target processor. When a processor's level moves from one nonzero value to another, its old line is dropped for one cycle before the new line is raised.

Top module: `irq_level_router`

## Requirements
- R1: After reset, every output line is low, the target processor is 0, the disable word is all zero and every private word is all zero.
- R2: Source i is pending while `src_in[i]` is high and stops being pending when it goes low. With the default table its level is i modulo 16. A change on `src_in` reaches the outputs on the second rising clock edge after it.
- R3: A source whose table level is 0 (sources 0 and 16 by default) is never pending and never affects any output.
- R4: Setting bit i of the disable word hides source i. Clearing the bit restores the source. The disable word is written with `wr_reg`=1, using `wr_set` and `wr_clr` as strobes.
- R5: While bit 31 of the disable word is set, no shared source contributes to any processor.
- R6: Shared sources reach only the target processor. The target is written with `wr_reg`=2, taking its value from the low bits of `wr_set`.
- R7: A soft write (`wr_reg`=0, processor `wr_cpu`) clears the bits given in `wr_clr` and then sets the bits given in `wr_set`, so set wins when both name the same bit. Only bits 17 to 31 are stored. Bit j requests level j−16, and writes to bits 0 to 16 have no effect.
- R8: A rising edge on `timer_in[c]` sets bit TIMER_BIT (default 30, level 14) of processor c's private word, and a falling edge clears it.
- R9: A processor's level is the maximum of its private levels and, if it is the target, the unmasked shared levels. Level k raises line bit k−1 only, and level 0 raises no line.
- R10: When a processor's level changes between two different nonzero values, all of its lines are low for exactly one cycle before the new line rises.
- R11: A change to a pending word, the disable word or the target shows on the outputs one clock edge after the register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 32 | Shared device request levels |
| timer_in | input | NUM_CPU | Per-processor timer request |
| wr_valid | input | 1 | Write strobe |
| wr_reg | input | 2 | Write target: 0 soft word, 1 disable word, 2 target select, 3 none |
| wr_cpu | input | CPU_W | Processor whose soft word is written |
| wr_set | input | 32 | Bits to set (target value in its low bits) |
| wr_clr | input | 32 | Bits to clear |
| lvl_line | output | NUM_CPU×15 | Per-processor one-hot level lines, bit k−1 for level k |

## Verification
The level selection is driven with single sources, overlapping sources whose levels rise and fall, soft bits that mix with a shared source on the target, and a timer whose bit is cleared by software while the timer stays high. Overlapping sources show whether the maximum is chosen and whether the one-cycle gap appears between two nonzero levels. A single source shows the two-edge latency. Zero-level sources, low soft bits and the disable word show whether ignored or masked requests stay off the lines. Changing the target while a source is held shows whether only the selected processor receives shared requests.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int SRC_N   = 32;
  localparam int LVL_W   = 4;
  localparam int LINE_N  = 15;
  localparam int SOFT_LO = 17;
  localparam logic [SRC_N-1:0] SOFT_FIELD = 32'hFFFE_0000;

  typedef logic [LVL_W-1:0]  lvl_t;
  typedef logic [LINE_N-1:0] line_t;

  typedef enum logic [1:0] {
    SEL_SOFT   = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_TARGET = 2'd2,
    SEL_NONE   = 2'd3
  } wsel_e;

  // default source-to-level table: source i gets level i mod 16
  function automatic logic [SRC_N*LVL_W-1:0] build_src_map();
    logic [SRC_N*LVL_W-1:0] m;
    m = '0;
    for (int i = 0; i < SRC_N; i++) m[i*LVL_W +: LVL_W] = lvl_t'(i % 16);
    return m;
  endfunction

  function automatic lvl_t src_level(input logic [SRC_N*LVL_W-1:0] map, input int idx);
    return map[idx*LVL_W +: LVL_W];
  endfunction

  // sources with a nonzero level are the only ones allowed to pend
  function automatic logic [SRC_N-1:0] live_sources(input logic [SRC_N*LVL_W-1:0] map);
    logic [SRC_N-1:0] r;
    for (int i = 0; i < SRC_N; i++) r[i] = (src_level(map, i) != '0);
    return r;
  endfunction

  function automatic lvl_t shared_max(input logic [SRC_N-1:0] pend,
                                      input logic [SRC_N*LVL_W-1:0] map);
    lvl_t best;
    best = '0;
    for (int i = 0; i < SRC_N; i++)
      if (pend[i] && (src_level(map, i) > best)) best = src_level(map, i);
    return best;
  endfunction

  // bit j (17..31) requests level j-16; ascending scan keeps the highest
  function automatic lvl_t soft_max(input logic [SRC_N-1:0] word);
    lvl_t best;
    best = '0;
    for (int j = SOFT_LO; j < SRC_N; j++)
      if (word[j]) best = lvl_t'(j - 16);
    return best;
  endfunction

  function automatic lvl_t lvl_max(input lvl_t a, input lvl_t b);
    return (a > b) ? a : b;
  endfunction

  function automatic line_t level_to_line(input lvl_t l);
    line_t r;
    r = '0;
    if (l != '0) r[int'(l) - 1] = 1'b1;
    return r;
  endfunction

  function automatic logic [SRC_N-1:0] apply_strobes(input logic [SRC_N-1:0] cur,
                                                     input logic [SRC_N-1:0] set_bits,
                                                     input logic [SRC_N-1:0] clr_bits);
    return (cur & ~clr_bits) | set_bits;
  endfunction
endpackage

// File: rtl/irq_shared_stage.sv
module irq_shared_stage
  import irq_route_pkg::*;
#(
  parameter int NUM_CPU = 16,
  parameter int CPU_W   = 4,
  parameter logic [SRC_N*LVL_W-1:0] SRC_MAP = build_src_map()
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] src_in,
  input  logic             wr_valid,
  input  wsel_e            wr_sel,
  input  logic [SRC_N-1:0] wr_set,
  input  logic [SRC_N-1:0] wr_clr,
  output logic [SRC_N-1:0] src_pend,
  output logic [SRC_N-1:0] dis_word,
  output logic [CPU_W-1:0] target_sel,
  output logic             shared_kill,
  output lvl_t             shared_lvl
);
  localparam logic [SRC_N-1:0] LIVE = live_sources(SRC_MAP);

  logic mask_wr, target_wr;
  logic [CPU_W-1:0] target_val;

  assign mask_wr    = wr_valid && (wr_sel == SEL_MASK);
  assign target_val = wr_set[CPU_W-1:0];
  assign target_wr  = wr_valid && (wr_sel == SEL_TARGET) && (int'(target_val) < NUM_CPU);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_pend   <= '0;
      dis_word   <= '0;
      target_sel <= '0;
    end else begin
      src_pend <= src_in & LIVE;
      if (mask_wr)   dis_word   <= apply_strobes(dis_word, wr_set, wr_clr);
      if (target_wr) target_sel <= target_val;
    end
  end

  assign shared_kill = dis_word[SRC_N-1];
  assign shared_lvl  = shared_kill ? '0 : shared_max(src_pend & ~dis_word, SRC_MAP);
endmodule

// File: rtl/irq_cpu_slice.sv
module irq_cpu_slice
  import irq_route_pkg::*;
#(
  parameter int TIMER_BIT = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             timer_in,
  input  logic             wr_hit,
  input  logic [SRC_N-1:0] wr_set,
  input  logic [SRC_N-1:0] wr_clr,
  input  logic             is_target,
  input  lvl_t             shared_lvl,
  output logic [SRC_N-1:0] priv_word,
  output lvl_t             priv_lvl,
  output lvl_t             want_lvl,
  output lvl_t             cur_lvl,
  output logic             drop_phase,
  output line_t            line
);
  logic timer_q, timer_rise, timer_fall;
  logic [SRC_N-1:0] priv_nxt;
  lvl_t cur_nxt;

  assign timer_rise = timer_in & ~timer_q;
  assign timer_fall = ~timer_in & timer_q;

  always_comb begin
    priv_nxt = priv_word;
    if (wr_hit) priv_nxt = apply_strobes(priv_word, wr_set, wr_clr) & SOFT_FIELD;
    if (timer_rise)      priv_nxt[TIMER_BIT] = 1'b1;
    else if (timer_fall) priv_nxt[TIMER_BIT] = 1'b0;
  end

  assign priv_lvl   = soft_max(priv_word);
  assign want_lvl   = lvl_max(priv_lvl, is_target ? shared_lvl : lvl_t'(0));
  // moving between two nonzero levels passes through zero for one cycle
  assign drop_phase = (cur_lvl != '0) && (want_lvl != '0) && (want_lvl != cur_lvl);
  assign cur_nxt    = drop_phase ? '0 : want_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_q   <= 1'b0;
      priv_word <= '0;
      cur_lvl   <= '0;
    end else begin
      timer_q   <= timer_in;
      priv_word <= priv_nxt;
      cur_lvl   <= cur_nxt;
    end
  end

  assign line = level_to_line(cur_lvl);
endmodule

// File: rtl/irq_level_router.sv
module irq_level_router
  import irq_route_pkg::*;
#(
  parameter int NUM_CPU   = 16,
  parameter int TIMER_BIT = 30,
  parameter logic [SRC_N*LVL_W-1:0] SRC_MAP = build_src_map(),
  localparam int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [SRC_N-1:0]               src_in,
  input  logic [NUM_CPU-1:0]             timer_in,
  input  logic                           wr_valid,
  input  logic [1:0]                     wr_reg,
  input  logic [CPU_W-1:0]               wr_cpu,
  input  logic [SRC_N-1:0]               wr_set,
  input  logic [SRC_N-1:0]               wr_clr,
  output logic [NUM_CPU-1:0][LINE_N-1:0] lvl_line
);
  wsel_e wr_sel;
  assign wr_sel = wsel_e'(wr_reg);

  logic [SRC_N-1:0] src_pend, dis_word;
  logic [CPU_W-1:0] target_sel;
  logic             shared_kill;
  lvl_t             shared_lvl;

  irq_shared_stage #(
    .NUM_CPU(NUM_CPU), .CPU_W(CPU_W), .SRC_MAP(SRC_MAP)
  ) u_shared (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .wr_valid(wr_valid), .wr_sel(wr_sel), .wr_set(wr_set), .wr_clr(wr_clr),
    .src_pend(src_pend), .dis_word(dis_word), .target_sel(target_sel),
    .shared_kill(shared_kill), .shared_lvl(shared_lvl)
  );

  logic [NUM_CPU-1:0][SRC_N-1:0] cpu_priv_word;
  logic [NUM_CPU-1:0][LVL_W-1:0] cpu_priv_lvl, cpu_want, cpu_cur;
  logic [NUM_CPU-1:0]            cpu_drop, cpu_hit, cpu_is_tgt;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    assign cpu_hit[c]    = wr_valid && (wr_sel == SEL_SOFT) && (wr_cpu == CPU_W'(c));
    assign cpu_is_tgt[c] = (target_sel == CPU_W'(c));

    irq_cpu_slice #(.TIMER_BIT(TIMER_BIT)) u_slice (
      .clk(clk), .rst_n(rst_n), .timer_in(timer_in[c]),
      .wr_hit(cpu_hit[c]), .wr_set(wr_set), .wr_clr(wr_clr),
      .is_target(cpu_is_tgt[c]), .shared_lvl(shared_lvl),
      .priv_word(cpu_priv_word[c]), .priv_lvl(cpu_priv_lvl[c]),
      .want_lvl(cpu_want[c]), .cur_lvl(cpu_cur[c]),
      .drop_phase(cpu_drop[c]), .line(lvl_line[c])
    );
  end
endmodule

// File: rtl/irq_level_router_chk.sv
module irq_level_router_chk
  import irq_route_pkg::*;
#(
  parameter int NUM_CPU = 16,
  parameter int CPU_W   = 4
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [NUM_CPU-1:0][LINE_N-1:0] lvl_line,
  input logic [NUM_CPU-1:0][LVL_W-1:0]  cpu_want,
  input logic [NUM_CPU-1:0][LVL_W-1:0]  cpu_cur,
  input logic [NUM_CPU-1:0][LVL_W-1:0]  cpu_priv_lvl,
  input logic [CPU_W-1:0]               target_sel,
  input logic [SRC_N-1:0]               dis_word,
  input logic [LVL_W-1:0]               shared_lvl
);
  assert_kill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dis_word[SRC_N-1] |-> (shared_lvl == '0));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
    assert_line_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lvl_line[c]));

    assert_private_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_want[c] >= cpu_priv_lvl[c]);

    assert_break_before_make_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(lvl_line[c]) != '0) && (lvl_line[c] != '0)) |-> (lvl_line[c] == $past(lvl_line[c])));

    assert_idle_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_cur[c] == '0) |=> (cpu_cur[c] == $past(cpu_want[c])));

    assert_settled_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_cur[c] == cpu_want[c]) |=> $stable(cpu_cur[c]));

    assert_nontarget_private_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (target_sel != CPU_W'(c)) |-> (cpu_want[c] == cpu_priv_lvl[c]));
  end
endmodule

bind irq_level_router irq_level_router_chk #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lvl_line(lvl_line), .cpu_want(cpu_want),
  .cpu_cur(cpu_cur), .cpu_priv_lvl(cpu_priv_lvl), .target_sel(target_sel),
  .dis_word(dis_word), .shared_lvl(shared_lvl)
);

// File: tb/test_irq_level_router.sv
`timescale 1ns/1ps
module test_irq_level_router;
  localparam int NC = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] src_in = '0;
  logic [NC-1:0] timer_in = '0;
  logic wr_valid = 1'b0;
  logic [1:0] wr_reg = 2'd3;
  logic [3:0] wr_cpu = '0;
  logic [31:0] wr_set = '0, wr_clr = '0;
  logic [NC-1:0][14:0] lvl_line;

  int n_checks = 0, n_errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_level_router i_irq_level_router (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .timer_in(timer_in),
    .wr_valid(wr_valid), .wr_reg(wr_reg), .wr_cpu(wr_cpu),
    .wr_set(wr_set), .wr_clr(wr_clr), .lvl_line(lvl_line)
  );

  function automatic logic [14:0] exp_line(input int lvl);
    return (lvl == 0) ? 15'd0 : (15'd1 << (lvl - 1));
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_lvl(input int cpu, input int lvl, input string req);
    n_checks++;
    if (lvl_line[cpu] !== exp_line(lvl)) begin
      n_errors++;
      $display("FAIL %s cpu%0d: got %b expected %b", req, cpu, lvl_line[cpu], exp_line(lvl));
    end
  endtask

  task automatic wr(input int sel, input int cpu, input logic [31:0] s, input logic [31:0] c);
    wr_valid = 1'b1; wr_reg = 2'(sel); wr_cpu = 4'(cpu); wr_set = s; wr_clr = c;
    @(negedge clk);
    wr_valid = 1'b0; wr_reg = 2'd3; wr_set = '0; wr_clr = '0;
  endtask

  task automatic t_reset();
    n_checks++;
    if (lvl_line !== '0) begin
      n_errors++;
      $display("FAIL R1 reset lines: got %h expected 0", lvl_line);
    end
  endtask

  task automatic t_shared();
    src_in[5] = 1'b1;
    step(1); check_lvl(0, 0, "R11 not yet after one edge");
    step(1); check_lvl(0, 5, "R2 source 5");
    src_in[9] = 1'b1;
    step(2); check_lvl(0, 0, "R10 gap on rise 5->9");
    step(1); check_lvl(0, 9, "R9 max of 5 and 9");
    src_in[9] = 1'b0;
    step(2); check_lvl(0, 0, "R10 gap on fall 9->5");
    step(1); check_lvl(0, 5, "R2 back to 5");
    src_in[5] = 1'b0;
    step(2); check_lvl(0, 0, "R2 deassert clears");
  endtask

  task automatic t_ignored();
    src_in[0] = 1'b1; src_in[16] = 1'b1;
    step(2); check_lvl(0, 0, "R3 zero-level sources");
    step(2); check_lvl(0, 0, "R3 still quiet");
    src_in[0] = 1'b0; src_in[16] = 1'b0;
    step(2);
  endtask

  task automatic t_mask();
    src_in[12] = 1'b1;
    step(2); check_lvl(0, 12, "R4 source 12 live");
    wr(1, 0, 32'h0000_1000, 32'h0);
    step(1); check_lvl(0, 0, "R4 masked source 12");
    wr(1, 0, 32'h0, 32'h0000_1000);
    step(1); check_lvl(0, 12, "R4 unmasked source 12");
    src_in[12] = 1'b0;
    step(2);
  endtask

  task automatic t_kill();
    src_in[3] = 1'b1;
    step(2); check_lvl(0, 3, "R5 source 3 live");
    wr(1, 0, 32'h8000_0000, 32'h0);
    step(1); check_lvl(0, 0, "R5 global disable");
    wr(1, 0, 32'h0, 32'h8000_0000);
    step(1); check_lvl(0, 3, "R5 disable lifted");
    src_in[3] = 1'b0;
    step(2);
  endtask

  task automatic t_target();
    src_in[7] = 1'b1;
    step(2); check_lvl(0, 7, "R6 default target 0");
    wr(2, 0, 32'd5, 32'h0);
    step(1);
    check_lvl(5, 7, "R6 new target 5");
    check_lvl(0, 0, "R6 old target loses shared");
    check_lvl(4, 0, "R6 non-target quiet");
    wr(2, 0, 32'd0, 32'h0);
    src_in[7] = 1'b0;
    step(2);
    check_lvl(5, 0, "R6 cleared after restore");
  endtask

  task automatic t_soft();
    wr(0, 2, 32'h0010_0000, 32'h0);
    step(1); check_lvl(2, 4, "R7 soft bit 20 gives level 4");
    check_lvl(3, 0, "R7 other cpu unaffected");
    wr(0, 2, 32'h0200_0000, 32'h0);
    step(1); check_lvl(2, 0, "R10 gap 4->9");
    step(1); check_lvl(2, 9, "R7 soft bit 25 gives level 9");
    wr(0, 2, 32'h0001_FFFF, 32'h0);
    step(2); check_lvl(2, 9, "R7 low bits ignored");
    wr(0, 2, 32'h0200_0000, 32'h0200_0000);
    step(2); check_lvl(2, 9, "R7 set wins over clear");
    wr(0, 2, 32'h0, 32'h0210_0000);
    step(1); check_lvl(2, 0, "R7 cleared soft bits");
    wr(0, 2, 32'h0, 32'h0001_0000);
    wr(0, 2, 32'h0002_0000, 32'h0);
    step(1); check_lvl(2, 1, "R7 bit 17 gives level 1 and bit 16 stayed off");
    wr(0, 2, 32'h0, 32'h0002_0000);
    step(1);
  endtask

  task automatic t_timer();
    timer_in[1] = 1'b1;
    step(2); check_lvl(1, 14, "R8 timer rise level 14");
    wr(0, 1, 32'h0, 32'h4000_0000);
    step(1); check_lvl(1, 0, "R8 software clears timer bit");
    timer_in[1] = 1'b0;
    step(2); check_lvl(1, 0, "R8 fall keeps clear");
    timer_in[1] = 1'b1;
    step(2); check_lvl(1, 14, "R8 second rise");
    timer_in[1] = 1'b0;
    step(2); check_lvl(1, 0, "R8 fall clears");
  endtask

  task automatic t_max();
    wr(2, 0, 32'd3, 32'h0);
    wr(0, 3, 32'h0004_0000, 32'h0);
    step(1); check_lvl(3, 2, "R9 private level 2");
    src_in[11] = 1'b1;
    step(3); check_lvl(3, 11, "R9 shared 11 beats private 2");
    src_in[11] = 1'b0;
    step(3); check_lvl(3, 2, "R9 falls back to private 2");
    wr(0, 3, 32'h0, 32'h0004_0000);
    wr(2, 0, 32'd0, 32'h0);
    step(1); check_lvl(3, 0, "R9 all clear");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_shared();
    t_ignored();
    t_mask();
    t_kill();
    t_target();
    t_soft();
    t_timer();
    t_max();
    step(2);
    finish_run();
  end
endmodule